// File: doc/BRIEF.md
# Debug Cross-Trigger Channel Router

This block ties one processor's debug trigger events to a small group of shared broadcast channels. It sits between the core and an external channel matrix. Each trigger input (for example "core halted") can be placed onto any set of channels through its own channel-enable mask. Each trigger output (for example "debug request" or "restart") is raised when any channel in its own channel-enable mask is active. The channel values sent to the matrix come out on `ch_out`. The values the matrix returns, which hold events from every interface on the same matrix, come in on `ch_in`. A debugger can also write a channel mask to a pulse register. That fires a one-cycle pulse on those channels, both locally and toward the matrix, so a single write can halt or restart every connected core at the same moment.

Each trigger output works in one of two ways, chosen per output by a parameter. A latched output stays high until software writes a 1 to its bit of the acknowledge register. A pass-through output follows channel activity with one cycle of delay. The register port is a plain single-cycle write strobe with a combinational read. No part of this block carries a data stream, so no port has valid/ready flow control and nothing can push back on the register writer or on the channel buses.

Top module: `cti_xtrig`

## Requirements
- R1: After reset, every channel mask reads 0, the enable bit reads 0, `ch_out` is 0 and `trig_out` is 0, whatever `trig_in` carries.
- R2: While the enable bit (bit 0 at address 0x0) is 0, `ch_out` stays 0 and no trigger output rises, whatever the masks, `trig_in`, `ch_in` and pulse writes are.
- R3: While enabled, `ch_out[c]` equals, in the same cycle, the OR over every input i of (`trig_in[i]` AND bit c of input mask i), ORed with any application pulse on channel c. Input mask i is at address 0x4+i, and a mask of 0 connects nothing.
- R4: Writing mask M to the pulse register (address 0x2) drives exactly the channels in M onto `ch_out` for the single cycle after the write. Bit c of M is channel c, so 0x01 pulses channel 0 and 0x02 pulses channel 1.
- R5: A pass-through output n (output 1 by default) is high in the cycle after the one in which (`ch_in` OR local pulse) AND output mask n is nonzero, and is low otherwise. Output mask n is at address 0x8+n.
- R6: A latched output n (output 0 by default) goes high under the same condition and stays high. Writing the acknowledge register (address 0x1) with bit n set clears it in the following cycle. Writing a 0 in bit n leaves it unchanged.
- R7: If an acknowledge of bit n and a new channel hit on output n fall in the same cycle, the latched output stays high.
- R8: The masks read back in their low 4 bits with the upper bits 0. The enable bit reads back in bit 0. The acknowledge and pulse addresses always read 0.
- R9: Channel activity that arrives from the matrix on `ch_in`, including this block's own `ch_out` looped back, drives the matching trigger outputs. A halt input mapped to channel 0 therefore raises a debug request mapped to channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 4 | Register address: {group[1:0], index[1:0]} |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| trig_in | input | 2 | Trigger events from the core |
| trig_out | output | 2 | Trigger requests to the core |
| ch_in | input | 4 | Channel activity returned by the matrix |
| ch_out | output | 4 | Channel activity sent to the matrix |

## Verification
The input routing is swept over every pair of 4-bit input masks and every 2-bit `trig_in` value. This separates a mask bit that routes from one that does not, and it catches a swap between the two inputs. The pass-through output is swept over every output mask against every `ch_in` pattern, which tells a correct AND-reduce apart from an inverted or misaligned mask. Each nonzero pulse mask is written once to confirm that the pulse lasts exactly one cycle on the right channels. Directed sequences then cover acknowledge with 0 versus 1, acknowledge colliding with a fresh hit, a halt looped back through the matrix, and routing while the enable bit is off.

// File: rtl/cti_pkg.sv
package cti_pkg;
  typedef enum logic [1:0] {
    GRP_CTL  = 2'd0,
    GRP_INM  = 2'd1,
    GRP_OUTM = 2'd2,
    GRP_RSV  = 2'd3
  } grp_e;

  localparam int CTL_IDX_ENABLE = 0;
  localparam int CTL_IDX_ACK    = 1;
  localparam int CTL_IDX_PULSE  = 2;
endpackage

// File: rtl/cti_regs.sv
module cti_regs
  import cti_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [IDX_W+1:0]              addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic                          enable,
  output logic [N_IN-1:0][NUM_CH-1:0]   in_mask,
  output logic [N_OUT-1:0][NUM_CH-1:0]  out_mask,
  output logic [N_OUT-1:0]              ack_strobe,
  output logic [NUM_CH-1:0]             app_pulse
);
  localparam int ADDR_W = IDX_W + 2;

  grp_e             grp;
  logic [IDX_W-1:0] idx;

  assign grp = grp_e'(addr[ADDR_W-1 -: 2]);
  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable    <= 1'b0;
      in_mask   <= '0;
      out_mask  <= '0;
      app_pulse <= '0;
    end else begin
      app_pulse <= '0;
      if (we) begin
        case (grp)
          GRP_CTL: begin
            if (idx == IDX_W'(CTL_IDX_ENABLE)) enable <= wdata[0];
            if (idx == IDX_W'(CTL_IDX_PULSE))  app_pulse <= wdata[NUM_CH-1:0];
          end
          GRP_INM: begin
            for (int i = 0; i < N_IN; i++)
              if (idx == IDX_W'(i)) in_mask[i] <= wdata[NUM_CH-1:0];
          end
          GRP_OUTM: begin
            for (int n = 0; n < N_OUT; n++)
              if (idx == IDX_W'(n)) out_mask[n] <= wdata[NUM_CH-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ack_strobe = '0;
    if (we && grp == GRP_CTL && idx == IDX_W'(CTL_IDX_ACK))
      ack_strobe = wdata[N_OUT-1:0];
  end

  always_comb begin
    rdata = '0;
    case (grp)
      GRP_CTL: begin
        if (idx == IDX_W'(CTL_IDX_ENABLE)) rdata[0] = enable;
      end
      GRP_INM: begin
        for (int i = 0; i < N_IN; i++)
          if (idx == IDX_W'(i)) rdata[NUM_CH-1:0] = in_mask[i];
      end
      GRP_OUTM: begin
        for (int n = 0; n < N_OUT; n++)
          if (idx == IDX_W'(n)) rdata[NUM_CH-1:0] = out_mask[n];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cti_route.sv
module cti_route #(
  parameter int NUM_CH = 4,
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2
) (
  input  logic                          enable,
  input  logic [N_IN-1:0]               trig_in,
  input  logic [N_IN-1:0][NUM_CH-1:0]   in_mask,
  input  logic [N_OUT-1:0][NUM_CH-1:0]  out_mask,
  input  logic [NUM_CH-1:0]             app_pulse,
  input  logic [NUM_CH-1:0]             ch_in,
  output logic [NUM_CH-1:0]             ch_out,
  output logic [N_OUT-1:0]              hit
);
  logic [NUM_CH-1:0] gathered;
  logic [NUM_CH-1:0] live;

  always_comb begin
    gathered = '0;
    for (int i = 0; i < N_IN; i++)
      gathered = gathered | (in_mask[i] & {NUM_CH{trig_in[i]}});
    ch_out = enable ? (gathered | app_pulse) : '0;
  end

  always_comb begin
    live = enable ? (ch_in | app_pulse) : '0;
    for (int n = 0; n < N_OUT; n++)
      hit[n] = |(live & out_mask[n]);
  end
endmodule

// File: rtl/cti_outstage.sv
module cti_outstage #(
  parameter int               N_OUT       = 2,
  parameter logic [N_OUT-1:0] OUT_LATCHED = 'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] hit,
  input  logic [N_OUT-1:0] ack,
  output logic [N_OUT-1:0] trig_out
);
  for (genvar n = 0; n < N_OUT; n++) begin : g_out
    logic q;
    if (OUT_LATCHED[n]) begin : g_latch
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= hit[n] | (q & ~ack[n]);
      end
    end else begin : g_pass
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= hit[n];
      end
    end
    assign trig_out[n] = q;
  end
endmodule

// File: rtl/cti_xtrig.sv
module cti_xtrig #(
  parameter int                    NUM_CH      = 4,
  parameter int                    N_TRIG_IN   = 2,
  parameter int                    N_TRIG_OUT  = 2,
  parameter int                    IDX_W       = 2,
  parameter int                    DATA_W      = 8,
  parameter logic [N_TRIG_OUT-1:0] OUT_LATCHED = 'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [IDX_W+1:0]      reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [N_TRIG_IN-1:0]  trig_in,
  output logic [N_TRIG_OUT-1:0] trig_out,
  input  logic [NUM_CH-1:0]     ch_in,
  output logic [NUM_CH-1:0]     ch_out
);
  logic                                ctl_enable;
  logic [N_TRIG_IN-1:0][NUM_CH-1:0]    in_mask;
  logic [N_TRIG_OUT-1:0][NUM_CH-1:0]   out_mask;
  logic [N_TRIG_OUT-1:0]               ack_strobe;
  logic [NUM_CH-1:0]                   app_pulse;
  logic [N_TRIG_OUT-1:0]               route_hit;

  cti_regs #(
    .NUM_CH(NUM_CH), .N_IN(N_TRIG_IN), .N_OUT(N_TRIG_OUT),
    .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .enable(ctl_enable),
    .in_mask(in_mask), .out_mask(out_mask), .ack_strobe(ack_strobe),
    .app_pulse(app_pulse)
  );

  cti_route #(
    .NUM_CH(NUM_CH), .N_IN(N_TRIG_IN), .N_OUT(N_TRIG_OUT)
  ) u_route (
    .enable(ctl_enable), .trig_in(trig_in), .in_mask(in_mask),
    .out_mask(out_mask), .app_pulse(app_pulse), .ch_in(ch_in),
    .ch_out(ch_out), .hit(route_hit)
  );

  cti_outstage #(
    .N_OUT(N_TRIG_OUT), .OUT_LATCHED(OUT_LATCHED)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .hit(route_hit), .ack(ack_strobe),
    .trig_out(trig_out)
  );
endmodule

// File: rtl/cti_xtrig_chk.sv
module cti_xtrig_chk
  import cti_pkg::*;
#(
  parameter int                    NUM_CH      = 4,
  parameter int                    N_TRIG_OUT  = 2,
  parameter int                    IDX_W       = 2,
  parameter int                    DATA_W      = 8,
  parameter logic [N_TRIG_OUT-1:0] OUT_LATCHED = 'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [IDX_W+1:0]      reg_addr,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic [DATA_W-1:0]     reg_rdata,
  input logic [NUM_CH-1:0]     ch_out,
  input logic [N_TRIG_OUT-1:0] trig_out,
  input logic                  enable,
  input logic [N_TRIG_OUT-1:0] hit
);
  localparam logic [IDX_W+1:0] A_ACK   = {GRP_CTL, IDX_W'(CTL_IDX_ACK)};
  localparam logic [IDX_W+1:0] A_PULSE = {GRP_CTL, IDX_W'(CTL_IDX_PULSE)};

  logic ack_wr, pulse_wr;
  assign ack_wr   = reg_we && (reg_addr == A_ACK);
  assign pulse_wr = reg_we && (reg_addr == A_PULSE);

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (ch_out == '0)); // R2

  AST_PULSE_REACHES_CHOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_wr && enable) |=> ((ch_out & $past(reg_wdata[NUM_CH-1:0])) == $past(reg_wdata[NUM_CH-1:0]))); // R4

  AST_STROBES_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == A_ACK) || (reg_addr == A_PULSE)) |-> (reg_rdata == '0)); // R8

  for (genvar n = 0; n < N_TRIG_OUT; n++) begin : g_chk
    if (OUT_LATCHED[n]) begin : g_latch
      AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out[n] && !(ack_wr && reg_wdata[n])) |=> trig_out[n]); // R6
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && reg_wdata[n] && !hit[n]) |=> !trig_out[n]); // R6
      AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        hit[n] |=> trig_out[n]); // R7
    end else begin : g_pass
      AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[n] |=> !trig_out[n]); // R5
    end
  end
endmodule

bind cti_xtrig cti_xtrig_chk #(
  .NUM_CH(NUM_CH), .N_TRIG_OUT(N_TRIG_OUT), .IDX_W(IDX_W),
  .DATA_W(DATA_W), .OUT_LATCHED(OUT_LATCHED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_out(ch_out),
  .trig_out(trig_out), .enable(ctl_enable), .hit(route_hit)
);

// File: tb/cti_xtrig_test.sv
`timescale 1ns/1ps
module cti_xtrig_test;
  localparam logic [3:0] A_CTRL = 4'h0, A_ACK = 4'h1, A_PULSE = 4'h2;
  localparam logic [3:0] A_IN0 = 4'h4, A_IN1 = 4'h5, A_OUT0 = 4'h8, A_OUT1 = 4'h9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] trig_in = 2'b11;
  logic [1:0] trig_out;
  logic [3:0] ext_ch = '0;
  logic [3:0] ch_in;
  logic [3:0] ch_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  // matrix model: own channels looped back plus events from another interface
  assign ch_in = ch_out | ext_ch;

  cti_xtrig uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .trig_out(trig_out), .ch_in(ch_in), .ch_out(ch_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: quiet after reset even with trig_in high
    #1 check("R1 ch_out", int'(ch_out), 0);
    check("R1 trig_out", int'(trig_out), 0);
    rd(A_CTRL, d); check("R1 enable", int'(d), 0);
    rd(A_IN0, d);  check("R1 in0", int'(d), 0);
    rd(A_IN1, d);  check("R1 in1", int'(d), 0);
    rd(A_OUT0, d); check("R1 out0", int'(d), 0);
    rd(A_OUT1, d); check("R1 out1", int'(d), 0);

    // R2: routing gated while disabled
    wr(A_IN0, 8'h0F); wr(A_IN1, 8'h0F); wr(A_OUT0, 8'h0F); wr(A_OUT1, 8'h0F);
    check("R2 ch_out masks", int'(ch_out), 0);
    wr(A_PULSE, 8'h0F);
    check("R2 ch_out pulse", int'(ch_out), 0);
    ext_ch = 4'hF;
    @(negedge clk); @(negedge clk);
    check("R2 trig_out", int'(trig_out), 0);
    ext_ch = 4'h0;
    wr(A_OUT0, 8'h00); wr(A_OUT1, 8'h00);
    wr(A_CTRL, 8'h01);

    // R3: exhaustive input routing
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        wr(A_IN0, 8'(a)); wr(A_IN1, 8'(b));
        for (int t = 0; t < 4; t++) begin
          @(negedge clk);
          trig_in = 2'(t);
          #1 check("R3 ch_out", int'(ch_out),
                   ((t & 1) != 0 ? a : 0) | ((t & 2) != 0 ? b : 0));
        end
      end
    end
    trig_in = 2'b00;

    // R8: register readback
    wr(A_IN0, 8'hA5); rd(A_IN0, d); check("R8 in0 readback", int'(d), 5);
    wr(A_IN1, 8'h00); rd(A_IN1, d); check("R8 in1 readback", int'(d), 0);
    wr(A_OUT1, 8'h3C); rd(A_OUT1, d); check("R8 out1 readback", int'(d), 12);
    rd(A_CTRL, d); check("R8 enable readback", int'(d), 1);
    rd(A_ACK, d);  check("R8 ack reads zero", int'(d), 0);
    rd(A_PULSE, d); check("R8 pulse reads zero", int'(d), 0);
    wr(A_IN0, 8'h00); wr(A_OUT1, 8'h00);

    // R4: every pulse mask lasts one cycle on its own channels
    for (int m = 1; m < 16; m++) begin
      wr(A_PULSE, 8'(m));
      check("R4 pulse present", int'(ch_out), m);
      @(negedge clk);
      check("R4 pulse gone", int'(ch_out), 0);
    end

    // R5: pass-through output over every mask / channel pattern
    for (int m = 0; m < 16; m++) begin
      wr(A_OUT1, 8'(m));
      for (int e = 0; e < 16; e++) begin
        @(negedge clk); ext_ch = 4'(e);
        @(negedge clk); ext_ch = 4'h0;
        check("R5 pass high", int'(trig_out[1]), ((e & m) != 0) ? 1 : 0);
        @(negedge clk);
        check("R5 pass low", int'(trig_out[1]), 0);
      end
    end
    // R5 / R4: restart pulse via 0x02 on channel 1
    wr(A_OUT1, 8'h02); wr(A_OUT0, 8'h01);
    wr(A_PULSE, 8'h02);
    check("R5 not yet", int'(trig_out[1]), 0);
    @(negedge clk); check("R5 restart pulse", int'(trig_out), 2);
    @(negedge clk); check("R5 restart ends", int'(trig_out), 0);

    // R6: halt pulse 0x01 latches output 0, ack 0 keeps, ack 1 clears
    wr(A_OUT1, 8'h00);
    wr(A_PULSE, 8'h01);
    @(negedge clk); check("R6 latched", int'(trig_out[0]), 1);
    repeat (3) @(negedge clk);
    check("R6 holds", int'(trig_out[0]), 1);
    wr(A_ACK, 8'h00); check("R6 ack zero no effect", int'(trig_out[0]), 1);
    wr(A_ACK, 8'h01); check("R6 ack clears", int'(trig_out[0]), 0);

    // R9: external channel and looped-back halt both raise output 0
    @(negedge clk); ext_ch = 4'h1;
    @(negedge clk); ext_ch = 4'h0;
    check("R9 external channel", int'(trig_out[0]), 1);
    wr(A_ACK, 8'h01); check("R9 ack", int'(trig_out[0]), 0);
    wr(A_IN0, 8'h01);
    @(negedge clk); trig_in = 2'b01;
    @(negedge clk); trig_in = 2'b00;
    check("R9 halt via matrix", int'(trig_out[0]), 1);
    wr(A_ACK, 8'h01); check("R9 halt ack", int'(trig_out[0]), 0);

    // R7: ack colliding with a fresh hit keeps the output set
    @(negedge clk); ext_ch = 4'h1;
    @(negedge clk);
    wr(A_ACK, 8'h01); check("R7 set beats ack", int'(trig_out[0]), 1);
    ext_ch = 4'h0;
    wr(A_ACK, 8'h01); check("R7 later ack clears", int'(trig_out[0]), 0);

    finish_run();
  end
endmodule